// File: doc/BRIEF.md
# Masked Sequencer Compare with Teach

This block checks a machine's input word against an expected pattern for the current step of a repeating cycle. It holds a small table of reference words and a position index. While compare is enabled, a found flag reports whether the source word equals the reference word at the current position, counting only the bits that the mask selects. A rising edge on the step input moves the position to the next entry. After the last step the position returns to entry 1, so entry 0 is used only as the startup pattern after reset.

A teach mode fills the table. An operator jogs the machine through its cycle and pulses the step input once per step. On each pulse the block moves to the next position and stores the whole source word at that position, with no mask applied. Found stays low in teach mode. Control and status pins are plain levels. The step edge is the only qualifier on the source word, and the block never applies back-pressure: a capture in teach mode always completes in the clock cycle that sees the edge. A combinational read port exposes any table entry.

Top module: `mask_seq_compare`

## Requirements
- R1: After reset the position is 0 and every table entry is 0. With a length of 7, done is 0.
- R2: With enable high in compare mode (mode 0), found is 1 exactly when `(src ^ ref[pos]) & mask` is zero. A mask bit of 1 includes that bit in the comparison, so mask F000h compares only bits 15 to 12.
- R3: With enable low, found is 0.
- R4: A rising edge on step changes the position at the next clock edge. If the position is below the length, it becomes position + 1. Holding step high advances the position only once.
- R5: A step edge taken when the position is at or above the length moves the position to 1, never to 0. Position 0 is reached only through reset.
- R6: Done is 1 exactly when the position equals the length. A length above depth − 1 is treated as depth − 1.
- R7: In teach mode (mode 1), a step edge advances the position as in R4 and R5. It also writes the full source word, unmasked, into the entry at the new position. Other entries keep their values.
- R8: In teach mode, found is 0.
- R9: In compare mode, step edges leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Compare enable |
| mode_i | input | 1 | 0 = compare, 1 = teach |
| step_i | input | 1 | Step level; its rising edge advances the position |
| src_i | input | WIDTH | Source word |
| mask_i | input | WIDTH | Compare mask, 1 = bit included |
| len_i | input | PW | Last step index (length) |
| found_o | output | 1 | Masked match at the current position |
| done_o | output | 1 | Position equals the length |
| pos_o | output | PW | Current position |
| rd_addr_i | input | PW | Table read address |
| rd_data_o | output | WIDTH | Table entry at rd_addr_i |

## Verification
The bench teaches every entry with arithmetic patterns, reads the table back, and then sweeps single-bit mismatches across all 16 bits at every position under a full mask, a mask that excludes the flipped bit, and mask F000h. A compare that ignored the mask, or inverted its sense, would flip found on at least one bit of that sweep. The bench also drives the wrap from the last step, both in teach mode and after the length is shortened. A design that returned to 0 would show position 0 and overwrite the startup word in teach mode. It also holds step high for several cycles, which catches a level-triggered advance, and reads the table after compare-mode stepping, which catches a write that leaks through outside teach mode.

// File: rtl/seqcmp_pkg.sv
package seqcmp_pkg;
  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_TEACH = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/seqcmp_edge.sv
module seqcmp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  // R4
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/seqcmp_index.sv
module seqcmp_index #(
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic [PW-1:0] len_i,
  output logic [PW-1:0] pos_o,
  output logic [PW-1:0] next_o,
  output logic          done_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [PW-1:0] FIRST_STEP = PW'(1);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] len_eff;
  logic          at_end;

  assign len_eff = (len_i > LAST) ? LAST : len_i;
  assign at_end  = (pos_q >= len_eff);
  assign next_o  = at_end ? FIRST_STEP : pos_q + FIRST_STEP;
  assign done_o  = (pos_q == len_eff);
  assign pos_o   = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos_q <= '0;
    else if (adv_i) pos_q <= next_o;
  end

  // R4
  pos_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && (pos_q < len_eff)) |=> (pos_q == PW'($past(pos_q) + 1'b1)));
  // R4
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(pos_q));
  // R5
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && at_end) |=> (pos_q == FIRST_STEP));
  // R5
  no_return_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != '0) |=> (pos_q != '0));
endmodule

// File: rtl/seqcmp_table.sv
module seqcmp_table #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [PW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [PW-1:0]    ref_addr_i,
  output logic [WIDTH-1:0] ref_o,
  input  logic [PW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_o
);
  logic [DEPTH-1:0][WIDTH-1:0] mem;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    mem[e] <= '0;
      else if (wr_en_i && (wr_addr_i == PW'(e)))     mem[e] <= wr_data_i;
    end
  end

  assign ref_o = (int'(ref_addr_i) < DEPTH) ? mem[ref_addr_i] : '0;
  assign rd_o  = (int'(rd_addr_i)  < DEPTH) ? mem[rd_addr_i]  : '0;

  // R7
  teach_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mem[$past(wr_addr_i)] == $past(wr_data_i)));
  // R9
  table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mem));
endmodule

// File: rtl/seqcmp_match.sv
module seqcmp_match #(
  parameter int WIDTH = 16
) (
  input  logic             active_i,
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] ref_i,
  output logic             found_o
);
  logic [WIDTH-1:0] miss;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign miss[b] = mask_i[b] & (src_i[b] ^ ref_i[b]);
  end

  assign found_o = active_i & ~(|miss);
endmodule

// File: rtl/mask_seq_compare.sv
module mask_seq_compare
  import seqcmp_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [PW-1:0]    len_i,
  output logic             found_o,
  output logic             done_o,
  output logic [PW-1:0]    pos_o,
  input  logic [PW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  seq_mode_e        mode;
  logic             step_rise;
  logic             teaching;
  logic [PW-1:0]    next_pos;
  logic [WIDTH-1:0] ref_word;

  assign mode     = seq_mode_e'(mode_i);
  assign teaching = (mode == MODE_TEACH);

  seqcmp_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (step_i),
    .rise_o  (step_rise)
  );

  seqcmp_index #(.DEPTH(DEPTH), .PW(PW)) u_index (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (step_rise),
    .len_i  (len_i),
    .pos_o  (pos_o),
    .next_o (next_pos),
    .done_o (done_o)
  );

  seqcmp_table #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (step_rise & teaching),
    .wr_addr_i  (next_pos),
    .wr_data_i  (src_i),
    .ref_addr_i (pos_o),
    .ref_o      (ref_word),
    .rd_addr_i  (rd_addr_i),
    .rd_o       (rd_data_o)
  );

  seqcmp_match #(.WIDTH(WIDTH)) u_match (
    .active_i (en_i & ~teaching),
    .src_i    (src_i),
    .mask_i   (mask_i),
    .ref_i    (ref_word),
    .found_o  (found_o)
  );

  // R3
  found_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !found_o);
  // R8
  found_teach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 1'b1) |-> !found_o);
  // R2
  found_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> ((src_i & mask_i) == (ref_word & mask_i)));
endmodule

// File: tb/mask_seq_compare_tb.sv
module mask_seq_compare_tb;
  localparam int W = 16;
  localparam int DEPTH = 8;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b1, mode_i = 1'b0, step_i = 1'b0;
  logic [W-1:0] src_i = '0, mask_i = 16'hFFFF;
  logic [PW-1:0] len_i = 3'd7, rd_addr_i = '0;
  logic found_o, done_o;
  logic [PW-1:0] pos_o;
  logic [W-1:0] rd_data_o;

  int checks = 0, fails = 0;
  int exp_pos = 0;
  int exp_len = 7;
  logic [W-1:0] exp_tab [DEPTH];

  always #10 clk = ~clk;

  mask_seq_compare u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i), .step_i(step_i),
    .src_i(src_i), .mask_i(mask_i), .len_i(len_i), .found_o(found_o),
    .done_o(done_o), .pos_o(pos_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern(input int k);
    return W'((k * 16'h3B1D) ^ 16'h5A0F);
  endfunction

  function automatic int next_of(input int p);
    return (p >= exp_len) ? 1 : p + 1;
  endfunction

  task automatic do_step();
    @(negedge clk) step_i = 1'b1;
    @(negedge clk) step_i = 1'b0;
    exp_pos = next_of(exp_pos);
    if (mode_i) exp_tab[exp_pos] = src_i;
  endtask

  task automatic check_table(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr_i = PW'(a);
      #1;
      chk(rd_data_o == exp_tab[a], req, int'(rd_data_o), int'(exp_tab[a]));
    end
  endtask

  task automatic check_pos(input string req);
    chk(int'(pos_o) == exp_pos, req, int'(pos_o), exp_pos);
    chk(done_o == (exp_pos == exp_len), "R6 done", int'(done_o), int'(exp_pos == exp_len));
  endtask

  task automatic sweep_found();
    logic [W-1:0] r;
    r = exp_tab[exp_pos];
    src_i = r; mask_i = 16'hFFFF; #1;
    chk(found_o == 1'b1, "R2 exact match", int'(found_o), 1);
    for (int b = 0; b < W; b++) begin
      src_i = r ^ (W'(1) << b);
      mask_i = 16'hFFFF; #1;
      chk(found_o == 1'b0, "R2 full mask miss", int'(found_o), 0);
      mask_i = ~(W'(1) << b); #1;
      chk(found_o == 1'b1, "R2 masked-out bit", int'(found_o), 1);
      mask_i = 16'hF000; #1;
      chk(found_o == (b < 12), "R2 mask F000", int'(found_o), int'(b < 12));
      en_i = 1'b0; #1;
      chk(found_o == 1'b0, "R3 disabled", int'(found_o), 0);
      en_i = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) exp_tab[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pos_o == 0, "R1 pos", int'(pos_o), 0);
    chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
    check_table("R1 table");
    #1;
    chk(found_o == 1'b1, "R2 after reset", int'(found_o), 1);
    en_i = 1'b0; #1;
    chk(found_o == 1'b0, "R3 disabled", int'(found_o), 0);
    en_i = 1'b1;

    // R7 teach each entry
    mode_i = 1'b1;
    for (int k = 1; k < DEPTH; k++) begin
      src_i = pattern(k);
      do_step();
      check_pos("R7 teach pos");
      chk(found_o == 1'b0, "R8 teach found", int'(found_o), 0);
    end
    check_table("R7 teach table");

    // R5 teach wrap writes entry 1, not entry 0
    src_i = 16'hC3E1;
    do_step();
    check_pos("R5 teach wrap");
    check_table("R7 wrap table");

    // R4 held step advances once
    mode_i = 1'b0;
    @(negedge clk) step_i = 1'b1;
    repeat (4) @(negedge clk);
    step_i = 1'b0;
    exp_pos = next_of(exp_pos);
    @(negedge clk);
    check_pos("R4 held step");

    // R2/R3 sweep at every position including the wrap
    for (int s = 0; s < DEPTH; s++) begin
      sweep_found();
      check_pos("R4 compare step");
      do_step();
    end
    check_pos("R5 compare wrap");
    check_table("R9 table unchanged");

    // R5 shorter length
    len_i = 3'd3; exp_len = 3;
    for (int s = 0; s < 6; s++) begin
      do_step();
      check_pos("R5 short length");
    end
    check_table("R9 table unchanged");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule